// File: doc/BRIEF.md
# Video Timing Flag Decoder

This block sits on a 10-bit parallel digital video word stream that advances one word per pixel clock. It searches the stream for timing reference sequences, reads the field, vertical-blanking and horizontal-blanking bits from the last word of each sequence, and turns them into steady level flags. It also produces an active-low strobe that loads an external FIFO once per line at start of active video.

The horizontal flag has two forms, chosen by a mode input. In span mode, the flag covers the whole blanking interval, including the timing words at both ends. In bit mode, the flag copies the horizontal bit of the most recent sequence. Span mode must raise the flag on the first word of an end-of-active-video sequence, before that sequence has been fully received. For this reason every output describes the word presented four clocks earlier, and a downstream data path delays its words by the same amount.

Top module: `vtf_decoder`

## Requirements
- R1: While reset is held, and for the four clocks after it is released, the field, vertical and horizontal flags are low and the FIFO load strobe is high.
- R2: A timing sequence is the four consecutive words 3FFh, 000h, 000h, X. In X, bit 8 carries the field bit, bit 7 the vertical bit and bit 6 the horizontal bit. Horizontal bit 1 marks end of active video, and 0 marks start of active video. Any word can serve as X. Every output describes the word presented LAG = 4 clocks earlier.
- R3: The field flag takes bit 8 of each X word, aligned with that word, and holds between sequences. It stays low through field 1 and through progressive video.
- R4: The vertical flag takes bit 7 of each X word, aligned with that word, and holds between sequences.
- R5: With the mode input at 1, the horizontal flag takes bit 6 of each X word, aligned with that word, and holds between sequences.
- R6: With the mode input at 0, the horizontal flag rises on the 3FFh word that opens an end-of-active-video sequence. It stays high through the X word of the next start-of-active-video sequence and falls on the word after it.
- R7: The FIFO load strobe is low for exactly one clock, aligned with the X word of each start-of-active-video sequence, and high at all other times.
- R8: A broken preamble is ignored and changes no output. Examples are a non-zero second or third word, or a missing 3FFh.
- R9: With the mode input at 0, a start-of-active-video sequence that has no end-of-active-video sequence before it leaves the horizontal flag low.
- R10: The mode input is read on every clock. Changing it switches the horizontal flag between the two tracked forms on the next output, with no loss of state in either form.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Pixel clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| vid_i | input | DW (10) | Video word stream |
| hmode_i | input | 1 | Horizontal flag mode: 0 span, 1 bit |
| fld_o | output | 1 | Field flag, high in field 2 |
| vblank_o | output | 1 | Vertical blanking flag |
| hblank_o | output | 1 | Horizontal blanking flag |
| fifo_ld_n_o | output | 1 | Active-low FIFO load strobe |

## Verification
The bench builds the block with its default parameters: a 10-bit word, field, vertical and horizontal bits at 8, 7 and 6, and a four-word lag. These values make the standard preamble and bit positions the ones the stimulus uses. The four-word lag means the span-mode rising edge depends on a lookahead of exactly three words.

The reference model looks ahead in its record of the words it has driven and recomputes each flag for every aligned word. This covers interlaced and progressive lines, lines that start with a start-of-active-video sequence alone, broken preambles, mode changes in the middle of a line, and noise that is biased toward the preamble codes.

// File: rtl/vtf_pkg.sv
package vtf_pkg;

  // Decoded content of one recognized timing sequence.
  typedef struct packed {
    logic hit;  // an X word completed a valid preamble
    logic f;
    logic v;
    logic h;
  } trs_ev_t;

  typedef enum logic {
    HM_SPAN   = 1'b0,
    HM_TRSBIT = 1'b1
  } hmode_e;

  function automatic trs_ev_t make_event(input logic hit, input logic f,
                                         input logic v, input logic h);
    trs_ev_t e;
    e.hit = hit;
    e.f   = hit & f;
    e.v   = hit & v;
    e.h   = hit & h;
    return e;
  endfunction

endpackage

// File: rtl/vtf_trs_detect.sv
module vtf_trs_detect
  import vtf_pkg::*;
#(
  parameter int DW    = 10,
  parameter int F_POS = 8,
  parameter int V_POS = 7,
  parameter int H_POS = 6
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [DW-1:0] vid_i,
  output trs_ev_t       ev_q
);

  localparam int PRE_LEN = 3;

  logic [DW-1:0] hist_q [PRE_LEN];
  logic          pre_ok;
  trs_ev_t       ev_d;

  // Oldest history word must be all ones, the two newer ones all zeros.
  function automatic logic preamble_match(input logic [DW-1:0] w_old,
                                          input logic [DW-1:0] w_mid,
                                          input logic [DW-1:0] w_new);
    return (w_old == {DW{1'b1}}) && (w_mid == '0) && (w_new == '0);
  endfunction

  generate
    for (genvar g = 0; g < PRE_LEN; g++) begin : g_hist
      if (g == 0) begin : g_head
        always_ff @(posedge clk_i or negedge rst_ni) begin
          if (!rst_ni) hist_q[0] <= '0;
          else         hist_q[0] <= vid_i;
        end
      end else begin : g_tail
        always_ff @(posedge clk_i or negedge rst_ni) begin
          if (!rst_ni) hist_q[g] <= '0;
          else         hist_q[g] <= hist_q[g-1];
        end
      end
    end
  endgenerate

  assign pre_ok = preamble_match(hist_q[PRE_LEN-1], hist_q[1], hist_q[0]);
  assign ev_d   = make_event(pre_ok, vid_i[F_POS], vid_i[V_POS], vid_i[H_POS]);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ev_q <= '0;
    else         ev_q <= ev_d;
  end

  // A sequence needs three leading words, so two hits never sit back to back.
  assert_no_adjacent_hit_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ev_q.hit |=> !ev_q.hit);

endmodule

// File: rtl/vtf_align_pipe.sv
module vtf_align_pipe
  import vtf_pkg::*;
#(
  parameter int STAGES = 3
) (
  input  logic    clk_i,
  input  logic    rst_ni,
  input  trs_ev_t ev_i,
  output trs_ev_t ev_o
);

  trs_ev_t st_q [STAGES];

  generate
    for (genvar g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk_i or negedge rst_ni) begin
          if (!rst_ni) st_q[0] <= '0;
          else         st_q[0] <= ev_i;
        end
      end else begin : g_next
        always_ff @(posedge clk_i or negedge rst_ni) begin
          if (!rst_ni) st_q[g] <= '0;
          else         st_q[g] <= st_q[g-1];
        end
      end
    end
  endgenerate

  assign ev_o = st_q[STAGES-1];

endmodule

// File: rtl/vtf_flag_gen.sv
module vtf_flag_gen
  import vtf_pkg::*;
(
  input  logic    clk_i,
  input  logic    rst_ni,
  input  hmode_e  hmode_i,
  input  logic    eav_start_i,  // aligned word opens an end-of-active sequence
  input  trs_ev_t al_ev_i,      // event whose X word is the aligned word
  output logic    fld_o,
  output logic    vblank_o,
  output logic    hblank_o,
  output logic    fifo_ld_n_o
);

  logic al_xyz, al_sav;
  logic span_q, span_d;
  logic clr_pend_q;
  logic trsh_q, trsh_d;

  assign al_xyz = al_ev_i.hit;
  assign al_sav = al_ev_i.hit & ~al_ev_i.h;

  // Span form: set by an opening EAV word, cleared the word after a SAV X word.
  function automatic logic next_span(input logic set, input logic cur,
                                     input logic clr);
    return set | (cur & ~clr);
  endfunction

  assign span_d = next_span(eav_start_i, span_q, clr_pend_q);
  assign trsh_d = al_xyz ? al_ev_i.h : trsh_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      span_q      <= 1'b0;
      clr_pend_q  <= 1'b0;
      trsh_q      <= 1'b0;
      fld_o       <= 1'b0;
      vblank_o    <= 1'b0;
      hblank_o    <= 1'b0;
      fifo_ld_n_o <= 1'b1;
    end else begin
      span_q      <= span_d;
      clr_pend_q  <= al_sav;
      trsh_q      <= trsh_d;
      if (al_xyz) begin
        fld_o    <= al_ev_i.f;
        vblank_o <= al_ev_i.v;
      end
      hblank_o    <= (hmode_i == HM_TRSBIT) ? trsh_d : span_d;
      fifo_ld_n_o <= ~al_sav;
    end
  end

  assert_fv_hold_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !al_xyz |=> ($stable(fld_o) && $stable(vblank_o)));

  assert_v_capture_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    al_xyz |=> (vblank_o == $past(al_ev_i.v)));

  assert_hbit_follow_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hmode_i == HM_TRSBIT && al_xyz) |=> (hblank_o == $past(al_ev_i.h)));

  assert_span_rise_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hmode_i == HM_SPAN && eav_start_i) |=> hblank_o);

  assert_span_fall_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hmode_i == HM_SPAN && clr_pend_q && !eav_start_i) |=> !hblank_o);

  assert_load_at_sav_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    al_sav |=> !fifo_ld_n_o);

  assert_load_one_cycle_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !fifo_ld_n_o |=> fifo_ld_n_o);

endmodule

// File: rtl/vtf_decoder.sv
module vtf_decoder
  import vtf_pkg::*;
#(
  parameter int DW    = 10,
  parameter int F_POS = 8,
  parameter int V_POS = 7,
  parameter int H_POS = 6,
  parameter int LAG   = 4
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [DW-1:0] vid_i,
  input  logic          hmode_i,
  output logic          fld_o,
  output logic          vblank_o,
  output logic          hblank_o,
  output logic          fifo_ld_n_o
);

  localparam int PIPE_STAGES = LAG - 1;

  trs_ev_t head_ev;   // X word three words after the aligned word
  trs_ev_t al_ev;     // X word equal to the aligned word
  logic    eav_start;
  hmode_e  hmode;

  assign hmode = hmode_e'(hmode_i);

  vtf_trs_detect #(
    .DW(DW), .F_POS(F_POS), .V_POS(V_POS), .H_POS(H_POS)
  ) u_detect (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .vid_i (vid_i),
    .ev_q  (head_ev)
  );

  vtf_align_pipe #(.STAGES(PIPE_STAGES)) u_align (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .ev_i  (head_ev),
    .ev_o  (al_ev)
  );

  assign eav_start = head_ev.hit & head_ev.h;

  vtf_flag_gen u_flags (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .hmode_i    (hmode),
    .eav_start_i(eav_start),
    .al_ev_i    (al_ev),
    .fld_o      (fld_o),
    .vblank_o   (vblank_o),
    .hblank_o   (hblank_o),
    .fifo_ld_n_o(fifo_ld_n_o)
  );

  // Outputs stay at reset values until a full lag of words has passed.
  assert_reset_values_R1: assert property (@(posedge clk_i)
    !rst_ni |=> (!fld_o && !vblank_o && !hblank_o && fifo_ld_n_o));

endmodule

// File: tb/vtf_decoder_tb.sv
module vtf_decoder_tb;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [9:0] din = '0;
  logic       hmode = 1'b0;
  logic       fld, vbl, hbl, ld_n;

  int checks = 0;
  int fails = 0;
  string sect = "R1";

  logic [9:0] words[$];
  logic       modes[$];

  // reference state
  bit m_f = 0, m_v = 0, m_h1 = 0, m_h0 = 0, m_prev_sav = 0;

  always #2.5 clk = ~clk;

  vtf_decoder u_dut (
    .clk_i(clk), .rst_ni(rst_n), .vid_i(din), .hmode_i(hmode),
    .fld_o(fld), .vblank_o(vbl), .hblank_o(hbl), .fifo_ld_n_o(ld_n)
  );

  task automatic chk(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s [%s] k=%0d actual=%b expected=%b", req, sect,
               words.size(), act, exp);
    end
  endtask

  function automatic bit is_xyz(input int k);
    return k >= 3 && words[k-3] == 10'h3FF && words[k-2] == 10'h000 &&
           words[k-1] == 10'h000;
  endfunction

  // Compare outputs for aligned word k = newest - 4.
  task automatic compare();
    int  e = words.size() - 1;
    int  k = e - 4;
    bit  x, eav, lp;
    if (k < 0) begin
      chk("R1 F", fld, 1'b0); chk("R1 V", vbl, 1'b0);
      chk("R1 H", hbl, 1'b0); chk("R1 LD", ld_n, 1'b1);
      return;
    end
    x   = is_xyz(k);
    eav = is_xyz(k + 3) && words[k+3][6];
    if (x) begin
      m_f  = words[k][8];
      m_v  = words[k][7];
      m_h1 = words[k][6];
    end
    if (eav) m_h0 = 1;
    else if (m_prev_sav) m_h0 = 0;
    lp = x && !words[k][6];
    m_prev_sav = lp;
    chk("R3 F", fld, m_f);
    chk("R4 V", vbl, m_v);
    if (modes[e]) chk("R5 R10 H", hbl, m_h1);
    else          chk("R6 R10 H", hbl, m_h0);
    chk("R7 LD", ld_n, !lp);
  endtask

  task automatic push(input logic [9:0] w, input logic m);
    din = w; hmode = m;
    words.push_back(w); modes.push_back(m);
    @(negedge clk);
    compare();
  endtask

  function automatic logic [9:0] xyz(input bit f, input bit v, input bit h);
    return {1'b1, f, v, h, 6'b000000};
  endfunction

  task automatic trs(input bit f, input bit v, input bit h, input logic m);
    push(10'h3FF, m); push(10'h000, m); push(10'h000, m); push(xyz(f, v, h), m);
  endtask

  task automatic vline(input bit f, input bit v, input int blank, input int act,
                       input logic m);
    trs(f, v, 1, m);
    for (int i = 0; i < blank; i++) push(10'h040, m);
    trs(f, v, 0, m);
    for (int i = 0; i < act; i++) push(10'($urandom_range(4, 1019)), m);
  endtask

  initial begin
    #(5 * 20000);
    fails++;
    checks++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    // R1: reset state
    repeat (3) @(negedge clk);
    chk("R1 F", fld, 1'b0); chk("R1 V", vbl, 1'b0);
    chk("R1 H", hbl, 1'b0); chk("R1 LD", ld_n, 1'b1);
    rst_n = 1'b1;

    // R2 R3 R4 R6: interlaced frame, span mode
    sect = "R2";
    for (int i = 0; i < 2; i++) vline(0, 1, 6, 10, 0);
    for (int i = 0; i < 3; i++) vline(0, 0, 5, 12, 0);
    for (int i = 0; i < 2; i++) vline(1, 1, 6, 10, 0);
    for (int i = 0; i < 3; i++) vline(1, 0, 4, 9, 0);

    // R5: bit mode, progressive
    sect = "R5";
    for (int i = 0; i < 4; i++) vline(0, i < 2, 3, 8, 1);

    // R9: SAV alone in span mode
    sect = "R9";
    for (int i = 0; i < 6; i++) push(10'h200, 0);
    trs(0, 0, 0, 0);
    for (int i = 0; i < 8; i++) push(10'h123, 0);
    trs(0, 0, 0, 0);
    for (int i = 0; i < 4; i++) push(10'h040, 0);

    // R8: broken preambles
    sect = "R8";
    vline(1, 1, 2, 4, 0);
    push(10'h3FF, 0); push(10'h000, 0); push(10'h005, 0); push(xyz(0, 0, 1), 0);
    push(10'h3FE, 0); push(10'h000, 0); push(10'h000, 0); push(xyz(0, 0, 0), 0);
    push(10'h3FF, 0); push(10'h001, 0); push(10'h000, 0); push(xyz(0, 0, 1), 0);
    push(10'h000, 0); push(10'h000, 0); push(xyz(0, 0, 0), 0);
    for (int i = 0; i < 5; i++) push(10'h080, 0);

    // R10: mode changes mid-line
    sect = "R10";
    for (int i = 0; i < 6; i++) begin
      trs(i[0], 0, 1, 0);
      for (int j = 0; j < 6; j++) push(10'h040, logic'(j[1] ^ i[0]));
      trs(i[0], 0, 0, 1);
      for (int j = 0; j < 7; j++) push(10'h100, logic'(j[0]));
    end

    // noise biased toward preamble codes
    sect = "R2";
    for (int i = 0; i < 3000; i++) begin
      int r = $urandom_range(0, 9);
      logic [9:0] w;
      if (r < 3) w = 10'h3FF;
      else if (r < 7) w = 10'h000;
      else w = 10'($urandom);
      push(w, logic'($urandom_range(0, 1)));
    end

    for (int i = 0; i < 8; i++) push(10'h040, 0);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule